// File: doc/BRIEF.md
# Transfer Descriptor Buffer Addresser

This block plans and walks one data packet of a general transfer descriptor in a USB host controller. A start pulse hands it the descriptor's current buffer pointer, the pointer to the last byte of the buffer, the endpoint's maximum packet size and the bit time left in the frame. One cycle later it reports the chosen packet length and whether the packet fits in the rest of the frame.

If the packet fits, the block emits one byte address per cycle. The buffer may spread over two 4096-byte pages. When the walk passes the end of the first page, the upper 20 address bits switch from the current pointer to the buffer end pointer, and the low 12 bits wrap to zero. After the last byte, the block pulses a done strobe together with the updated current buffer pointer, which the descriptor write-back stage stores.

The bit time a packet needs is modelled as a fixed overhead parameter plus eight bit times per byte.

Top module: `td_buf_addresser`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `plan_vld_o`, `addr_vld_o` and `done_o` are all low.
- R2: A start accepted while idle makes `plan_vld_o` high for exactly one cycle, in the cycle after the accepting edge. `plan_len_o` then equals the smaller of the maximum packet size and the remaining buffer bytes.
- R3: The remaining bytes count is computed as follows. When both pointers share the same upper 20 bits, it is end[11:0] − cur[11:0] + 1. Otherwise it is 4096 − cur[11:0] + end[11:0] + 1.
- R4: A current pointer of zero gives zero remaining bytes. The packet length is then 0, no address beat is emitted, and if the packet fits, `done_o` follows the plan cycle with `new_cbp_o` = 0.
- R5: `plan_fit_o` is 1 exactly when OVH + 8·length ≤ `frame_left_i`. When it is 0, no address beat and no done strobe follow, and the block is idle again in the cycle after the plan cycle.
- R6: When the packet fits, `addr_vld_o` is high for exactly length consecutive cycles, starting the cycle after the plan cycle. The first address is the current pointer, and each following address is one higher within a page.
- R7: When the byte offset passes 0xFFF, the next address takes its upper 20 bits from the buffer end pointer and its low 12 bits restart at 0x000.
- R8: `done_o` pulses for one cycle right after the last address beat. `new_cbp_o` is 0 if the packet emptied the buffer; otherwise it is the address of the next untransferred byte, formed by the same page rule.
- R9: `start_i` is ignored while `busy_o` is high. Stimulus applied during a packet produces no extra plan, address or done events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to plan one packet |
| cbp_i | input | 32 | Current buffer pointer |
| be_i | input | 32 | Address of the last buffer byte |
| mps_i | input | 11 | Endpoint maximum packet size in bytes |
| frame_left_i | input | 16 | Bit times left in the frame |
| busy_o | output | 1 | A packet is being planned or walked |
| plan_vld_o | output | 1 | Plan result valid (one cycle) |
| plan_fit_o | output | 1 | Packet may start in this frame |
| plan_len_o | output | 11 | Chosen packet length in bytes |
| addr_vld_o | output | 1 | Byte address valid |
| addr_o | output | 32 | Byte address |
| done_o | output | 1 | Packet finished (one cycle) |
| new_cbp_o | output | 32 | Updated current buffer pointer |

## Verification
The bench builds the block with an overhead of 20 bit times and keeps every maximum packet size at 64 bytes or less. This keeps each walk short, so page crossings, exact fit boundaries and buffer-emptying cases all fit in a brief run. A frame budget of 16 bits gives room for values exactly at, and one below, the needed bit time. Buffer offsets near 0xFFF place the page switch inside a short packet and also exactly at the resume pointer.

// File: rtl/td_buf_pkg.sv
package td_buf_pkg;
  parameter int ADDR_W  = 32;
  parameter int PAGE_W  = 12;
  parameter int LEN_W   = 11;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int REM_W  = PAGE_W + 2;
  localparam int PAGE_SZ = 1 << PAGE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_PLAN, ST_XFER, ST_FIN} walk_state_e;

  // bytes left between cur and end, across at most one page switch
  function automatic logic [REM_W-1:0] remain_bytes(input logic [ADDR_W-1:0] cur,
                                                    input logic [ADDR_W-1:0] last);
    logic [REM_W-1:0] c, e;
    c = REM_W'(cur[PAGE_W-1:0]);
    e = REM_W'(last[PAGE_W-1:0]);
    if (cur == '0) return '0;
    if (cur[ADDR_W-1:PAGE_W] == last[ADDR_W-1:PAGE_W]) return e - c + REM_W'(1);
    return REM_W'(PAGE_SZ) - c + e + REM_W'(1);
  endfunction

  // address of byte idx counted from cur, switching page to last's upper bits
  function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] cur,
                                                  input logic [ADDR_W-1:0] last,
                                                  input logic [LEN_W-1:0] idx);
    logic [REM_W-1:0] sum;
    sum = REM_W'(cur[PAGE_W-1:0]) + REM_W'(idx);
    if (sum >= REM_W'(PAGE_SZ)) return {last[ADDR_W-1:PAGE_W], sum[PAGE_W-1:0]};
    return {cur[ADDR_W-1:PAGE_W], sum[PAGE_W-1:0]};
  endfunction

  function automatic logic [LEN_W+8:0] bit_need(input logic [LEN_W-1:0] len,
                                                input logic [15:0] ovh);
    return (LEN_W+9)'(ovh) + ((LEN_W+9)'(len) << 3);
  endfunction
endpackage

// File: rtl/td_buf_plan.sv
module td_buf_plan
  import td_buf_pkg::*;
#(
  parameter int FT_W = 16,
  parameter int OVH  = 20
) (
  input  logic [ADDR_W-1:0] cbp_i,
  input  logic [ADDR_W-1:0] be_i,
  input  logic [LEN_W-1:0]  mps_i,
  input  logic [FT_W-1:0]   frame_left_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              fit_o,
  output logic              empties_o
);
  localparam int NEED_W = LEN_W + 9;
  localparam int CMP_W  = (NEED_W > FT_W) ? NEED_W : FT_W;

  logic [REM_W-1:0]  rem_w;
  logic [NEED_W-1:0] need_w;

  always_comb begin
    rem_w = remain_bytes(cbp_i, be_i);
    if (REM_W'(mps_i) < rem_w) len_o = mps_i;
    else                       len_o = LEN_W'(rem_w);
    empties_o = (REM_W'(len_o) == rem_w);
    need_w    = bit_need(len_o, 16'(OVH));
    fit_o     = (CMP_W'(need_w) <= CMP_W'(frame_left_i));
  end
endmodule

// File: rtl/td_buf_walker.sv
module td_buf_walker
  import td_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] cbp_i,
  input  logic [ADDR_W-1:0] be_i,
  output logic [LEN_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_o <= '0;
    else if (clear_i) idx_o <= '0;
    else if (step_i)  idx_o <= idx_o + LEN_W'(1);
  end

  assign addr_o = page_addr(cbp_i, be_i, idx_o);
endmodule

// File: rtl/td_buf_addresser.sv
module td_buf_addresser
  import td_buf_pkg::*;
#(
  parameter int FT_W = 16,
  parameter int OVH  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       cbp_i,
  input  logic [31:0]       be_i,
  input  logic [10:0]       mps_i,
  input  logic [FT_W-1:0]   frame_left_i,
  output logic              busy_o,
  output logic              plan_vld_o,
  output logic              plan_fit_o,
  output logic [10:0]       plan_len_o,
  output logic              addr_vld_o,
  output logic [31:0]       addr_o,
  output logic              done_o,
  output logic [31:0]       new_cbp_o
);
  walk_state_e state_q, state_d;
  logic [ADDR_W-1:0] cbp_q, be_q, walk_addr;
  logic [LEN_W-1:0]  len_q, len_w, idx_w;
  logic              fit_q, fit_w, emp_q, emp_w;

  // named events for the checker
  logic accept_w, last_beat_w;

  td_buf_plan #(.FT_W(FT_W), .OVH(OVH)) u_plan (
    .cbp_i(cbp_i), .be_i(be_i), .mps_i(mps_i), .frame_left_i(frame_left_i),
    .len_o(len_w), .fit_o(fit_w), .empties_o(emp_w)
  );

  td_buf_walker u_walk (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_w), .step_i(addr_vld_o),
    .cbp_i(cbp_q), .be_i(be_q), .idx_o(idx_w), .addr_o(walk_addr)
  );

  assign accept_w    = start_i && (state_q == ST_IDLE);
  assign last_beat_w = (state_q == ST_XFER) && (idx_w == len_q - LEN_W'(1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_w) state_d = ST_PLAN;
      ST_PLAN: if (!fit_q) state_d = ST_IDLE;
               else if (len_q == '0) state_d = ST_FIN;
               else state_d = ST_XFER;
      ST_XFER: if (last_beat_w) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cbp_q   <= '0;
      be_q    <= '0;
      len_q   <= '0;
      fit_q   <= 1'b0;
      emp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        cbp_q <= cbp_i;
        be_q  <= be_i;
        len_q <= len_w;
        fit_q <= fit_w;
        emp_q <= emp_w;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign plan_vld_o = (state_q == ST_PLAN);
  assign plan_fit_o = fit_q;
  assign plan_len_o = len_q;
  assign addr_vld_o = (state_q == ST_XFER);
  assign addr_o     = walk_addr;
  assign done_o     = (state_q == ST_FIN);
  assign new_cbp_o  = emp_q ? '0 : walk_addr;
endmodule

// File: rtl/td_buf_addresser_chk.sv
module td_buf_addresser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept_w,
  input logic        busy_o,
  input logic        plan_vld_o,
  input logic        plan_fit_o,
  input logic        addr_vld_o,
  input logic [31:0] addr_o,
  input logic        done_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!plan_vld_o && !addr_vld_o && !done_o));
  // R2
  plan_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> plan_vld_o);
  // R2
  plan_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plan_vld_o |=> !plan_vld_o);
  // R5
  nofit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_vld_o && !plan_fit_o) |=> !busy_o);
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_o && $past(addr_vld_o) && (addr_o[11:0] != 12'h000)) |->
      (addr_o == $past(addr_o) + 32'd1));
  // R7
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_o && $past(addr_vld_o) && (addr_o[11:0] == 12'h000)) |->
      ($past(addr_o[11:0]) == 12'hFFF));
  // R8
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({plan_vld_o, addr_vld_o, done_o}));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

bind td_buf_addresser td_buf_addresser_chk u_chk (.*);

// File: tb/tb_td_buf_addresser.sv
module tb_td_buf_addresser;
  localparam int OVH = 20;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [31:0] cbp_i = '0, be_i = '0;
  logic [10:0] mps_i = '0;
  logic [15:0] frame_left_i = '0;
  logic busy_o, plan_vld_o, plan_fit_o, addr_vld_o, done_o;
  logic [10:0] plan_len_o;
  logic [31:0] addr_o, new_cbp_o;
  int tests = 0, fails = 0;
  int q_kind[$]; logic [31:0] q_val[$]; int q_req[$];

  always #2 clk = ~clk;

  td_buf_addresser #(.FT_W(16), .OVH(OVH)) dut (.*);

  task automatic check(input bit ok, input int req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL R%0d got %h expected %h", req, got, exp); end
  endtask

  // monitor: pops the scoreboard as events appear (kind 0 plan, 1 addr, 2 done)
  task automatic pop_cmp(input int kind, input logic [31:0] got);
    if (q_kind.size() == 0) begin
      check(0, 9, got, 32'hDEAD_0000 | 32'(kind)); // R9: unexpected event
    end else begin
      int k = q_kind.pop_front(); logic [31:0] v = q_val.pop_front(); int r = q_req.pop_front();
      check(k == kind && v == got, r, got, v);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (plan_vld_o) pop_cmp(0, {20'd0, plan_len_o, plan_fit_o});
    if (addr_vld_o) pop_cmp(1, addr_o);
    if (done_o)     pop_cmp(2, new_cbp_o);
  end

  function automatic logic [31:0] model_addr(logic [31:0] c, logic [31:0] e, int k);
    int off = int'(c[11:0]) + k;
    return (off >= 4096) ? {e[31:12], 12'(off - 4096)} : {c[31:12], 12'(off)};
  endfunction

  task automatic send(input logic [31:0] c, input logic [31:0] e, input int mps,
                      input int fl, input int req, input bit junk);
    int rem, len, vend; bit fit;
    if (c == 0) rem = 0;
    else begin
      vend = (c[31:12] == e[31:12]) ? int'(e[11:0]) : 4096 + int'(e[11:0]);
      rem = vend - int'(c[11:0]) + 1;
    end
    len = (mps < rem) ? mps : rem;
    fit = (OVH + 8 * len) <= fl;
    q_kind.push_back(0); q_val.push_back({20'd0, 11'(len), fit}); q_req.push_back(req);
    if (fit) begin
      for (int k = 0; k < len; k++) begin
        q_kind.push_back(1); q_val.push_back(model_addr(c, e, k)); q_req.push_back(req);
      end
      q_kind.push_back(2); q_req.push_back(req);
      q_val.push_back((len == rem) ? 32'd0 : model_addr(c, e, len));
    end
    @(negedge clk);
    while (busy_o) @(negedge clk);
    cbp_i = c; be_i = e; mps_i = 11'(mps); frame_left_i = 16'(fl); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) begin
      if (junk) begin start_i = 1'b1; cbp_i = 32'h0000_7000; mps_i = 11'd3; end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    check(q_kind.size() == 0 && !busy_o, req, 32'(q_kind.size()), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !plan_vld_o && !addr_vld_o && !done_o, 1,
          {28'd0, busy_o, plan_vld_o, addr_vld_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, 1, {31'd0, busy_o}, 32'd0); // R1
    send(32'h1234_5100, 32'h1234_5163, 16, 1000, 2, 0);   // R2, R6, R8 partial
    send(32'h1000_0010, 32'h1000_0019, 40, 1000, 3, 0);   // R3 same page, R8 empties
    send(32'h0000_2FFA, 32'h0005_6003, 16, 1000, 7, 0);   // R7, R3 crossing
    send(32'h0000_2FFC, 32'h0005_6100, 8, 1000, 7, 0);    // R7, R8 resume after switch
    send(32'h0000_0FF0, 32'h000A_B200, 16, 1000, 8, 0);   // R8 resume exactly at page start
    send(32'h0000_0000, 32'h0000_0000, 16, OVH, 4, 0);    // R4 zero-length
    send(32'h0000_0000, 32'h0000_0000, 16, OVH - 1, 4, 0); // R4 with no room, R5
    send(32'h2000_0000, 32'h2000_0FFF, 32, OVH + 255, 5, 0); // R5 one short
    send(32'h2000_0000, 32'h2000_0FFF, 32, OVH + 256, 5, 0); // R5 exact fit
    send(32'h3000_0400, 32'h3000_04FF, 12, 1000, 9, 1);   // R9 start during busy
    send(32'h3000_0F00, 32'h3000_0F00, 64, 1000, 6, 0);   // R6 single byte
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule